// File: doc/BRIEF.md
# Delayed Conversion-Start Sequencer

This block sits between a system that asks for analog-to-digital conversions and a converter with an end-of-conversion output (`conv_eoc`, high when idle, low while busy). Such converters ignore a start that arrives in a short guard window after they finish. A request can come from an unrelated clock domain at any moment. The block synchronises it and holds it in a set/reset request flag. It then passes the held request through a four-stage shift delay, so the converter never sees a start inside that window. A rising-edge detector on the last delay stage turns the held level into a start pulse that is one clock wide.

The flag clears itself one clock after the converter is seen busy after a start has been issued, so one request yields one conversion. The clear does not depend on a falling edge of `conv_eoc`. This means it also works when the pulse restarts a converter that is already busy. If the request is still asserted when the clear arrives, setting wins. The clear then only punches a one-clock gap into the delay line, and that gap produces the next start pulse.

Top module: `startreq_delay`

## Requirements
- R1: While `rst_n` is low, and after it is released with no request, `conv_start` stays low.
- R2: A request held for a single clock is captured and still yields exactly one start pulse after `start_req` has returned low.
- R3: With the default parameters, a rising `start_req` first sampled at clock edge k makes `conv_start` high in the cycle that follows edge k+6: two clocks of synchronisation, one clock into the flag and four delay stages.
- R4: `conv_start` is never high on two consecutive clock edges, including while `start_req` is held high.
- R5: One clock after `conv_eoc` is first sampled low following an issued pulse, the request flag clears. With no new request, no further pulse follows.
- R6: A request that arrives while the flag is still set is merged into it. A request made on the first clock after `conv_eoc` returns high is held, and its pulse reaches the converter at least four clocks after that rise.
- R7: If the synchronised request is high when the flag would clear, the flag stays set and another pulse follows. With `start_req` held high and the converter restarted by each pulse, pulses repeat every 7 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared with the converter |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Asynchronous conversion request, active high, any length |
| conv_eoc | input | 1 | Converter end-of-conversion, high when idle, low while converting |
| conv_start | output | 1 | One-clock start pulse to the converter |

## Verification
The bench builds the block with two synchroniser stages, four delay stages and a clear lag of one clock. At those values the latency from request to pulse is exactly seven sampled cycles, which makes the restart period under a held request measurable and fixed. The behavioural converter in the bench takes twelve clocks, and a new start restarts it. This brings within reach both the normal busy-then-idle sequence and the case where `conv_eoc` never rises between pulses, so the flag must clear without a falling edge.

// File: rtl/startreq_pkg.sv
package startreq_pkg;

   // Upper bound on any stage count, keeps elaborated chains small.
   localparam int unsigned SREQ_STAGE_CEIL = 64;

   function automatic bit sreq_depth_ok(input int n, input int lo);
      return (n >= lo) && (n <= int'(SREQ_STAGE_CEIL));
   endfunction

endpackage

// File: rtl/sreq_sync.sv
module sreq_sync
   import startreq_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);

   generate
      if (!sreq_depth_ok(STAGES, 2)) begin : g_bad_depth
         $error("sreq_sync: STAGES must lie in 2..%0d", SREQ_STAGE_CEIL);
      end
   endgenerate

   logic [STAGES-1:0] ff_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ff_q <= '0;
      end else begin
         ff_q[0] <= async_in;
         for (int i = 1; i < STAGES; i++) begin
            ff_q[i] <= ff_q[i-1];
         end
      end
   end

   assign sync_out = ff_q[STAGES-1];

endmodule

// File: rtl/sreq_latch.sv
module sreq_latch
   import startreq_pkg::*;
#(
   parameter int CLEAR_LAG = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_set,
   input  logic conv_eoc,
   input  logic pulse_issued,
   output logic latch_q,
   output logic clr_now,
   output logic latch_feed
);

   generate
      if (!sreq_depth_ok(CLEAR_LAG, 1)) begin : g_bad_lag
         $error("sreq_latch: CLEAR_LAG must lie in 1..%0d", SREQ_STAGE_CEIL);
      end
   endgenerate

   // Armed from the issued pulse until the converter is seen busy.
   logic arm_q;
   logic busy_seen;
   logic [CLEAR_LAG-1:0] lag_q;

   assign busy_seen = arm_q & ~conv_eoc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_q <= 1'b0;
      end else begin
         arm_q <= pulse_issued | (arm_q & conv_eoc);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lag_q <= '0;
      end else begin
         lag_q[0] <= busy_seen;
         for (int i = 1; i < CLEAR_LAG; i++) begin
            lag_q[i] <= lag_q[i-1];
         end
      end
   end

   assign clr_now = lag_q[CLEAR_LAG-1];

   // Set dominates clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q <= 1'b0;
      end else begin
         latch_q <= req_set | (latch_q & ~clr_now);
      end
   end

   // A clear cycle always shows as a gap in the delay line.
   assign latch_feed = latch_q & ~clr_now;

endmodule

// File: rtl/sreq_pulse.sv
module sreq_pulse
   import startreq_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   output logic delayed,
   output logic pulse
);

   generate
      if (!sreq_depth_ok(DEPTH, 1)) begin : g_bad_depth
         $error("sreq_pulse: DEPTH must lie in 1..%0d", SREQ_STAGE_CEIL);
      end
   endgenerate

   logic [DEPTH-1:0] stage_q;
   logic             prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         stage_q[0] <= level_in;
         for (int i = 1; i < DEPTH; i++) begin
            stage_q[i] <= stage_q[i-1];
         end
         prev_q <= stage_q[DEPTH-1];
      end
   end

   assign delayed = stage_q[DEPTH-1];
   assign pulse   = delayed & ~prev_q;

endmodule

// File: rtl/startreq_delay.sv
module startreq_delay
   import startreq_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int DELAY_STAGES = 4,
   parameter int CLEAR_LAG    = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_req,
   input  logic conv_eoc,
   output logic conv_start
);

   localparam int LATENCY = SYNC_STAGES + 1 + DELAY_STAGES;

   generate
      if (LATENCY > 3 * int'(SREQ_STAGE_CEIL)) begin : g_bad_total
         $error("startreq_delay: total latency %0d out of range", LATENCY);
      end
   endgenerate

   logic req_sync;
   logic latch_q;
   logic clr_now;
   logic latch_feed;
   logic delayed;

   sreq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (start_req),
      .sync_out (req_sync)
   );

   sreq_latch #(.CLEAR_LAG(CLEAR_LAG)) u_latch (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_set      (req_sync),
      .conv_eoc     (conv_eoc),
      .pulse_issued (conv_start),
      .latch_q      (latch_q),
      .clr_now      (clr_now),
      .latch_feed   (latch_feed)
   );

   sreq_pulse #(.DEPTH(DELAY_STAGES)) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (latch_feed),
      .delayed  (delayed),
      .pulse    (conv_start)
   );

endmodule

// File: rtl/startreq_delay_chk.sv
module startreq_delay_chk (
   input logic clk,
   input logic rst_n,
   input logic conv_start,
   input logic req_sync,
   input logic latch_q,
   input logic clr_now
);

   // R1
   quiet_after_reset_chk: assert property (@(posedge clk)
      $rose(rst_n) |-> !conv_start);

   // R4
   one_clock_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   // R2
   flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q && !clr_now) |=> latch_q);

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_sync |=> latch_q);

   // R5
   flag_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_now && !req_sync) |=> !latch_q);

endmodule

bind startreq_delay startreq_delay_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .conv_start (conv_start),
   .req_sync   (req_sync),
   .latch_q    (latch_q),
   .clr_now    (clr_now)
);

// File: tb/sim_startreq_delay.sv
module sim_startreq_delay;

   localparam int SYNC_N    = 2;
   localparam int DLY_N     = 4;
   localparam int LAG_N     = 1;
   localparam int CONV_CLKS = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start_req = 1'b0;
   logic conv_eoc;
   logic conv_start;

   always #10 clk = ~clk;

   startreq_delay #(
      .SYNC_STAGES(SYNC_N), .DELAY_STAGES(DLY_N), .CLEAR_LAG(LAG_N)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start_req(start_req),
      .conv_eoc(conv_eoc), .conv_start(conv_start)
   );

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;
   int busy = 0;
   int pulse_at[$];
   bit done = 1'b0;

   // Behavioural converter: start restarts it, busy CONV_CLKS clocks.
   always @(posedge clk) begin
      if (!rst_n) begin
         conv_eoc <= 1'b1;
         busy     <= 0;
      end else if (conv_start) begin
         conv_eoc <= 1'b0;
         busy     <= CONV_CLKS;
      end else if (busy > 0) begin
         busy <= busy - 1;
         if (busy == 1) conv_eoc <= 1'b1;
      end
   end

   // Reference model of the request path.
   bit sq[$], cq[$], dq[$];
   bit m_flag, m_arm, m_last, m_exp;

   task automatic model_clear();
      sq.delete(); cq.delete(); dq.delete();
      for (int i = 0; i < SYNC_N; i++) sq.push_front(1'b0);
      for (int i = 0; i < LAG_N; i++)  cq.push_front(1'b0);
      for (int i = 0; i < DLY_N; i++)  dq.push_front(1'b0);
      m_flag = 1'b0; m_arm = 1'b0; m_last = 1'b0; m_exp = 1'b0;
   endtask

   initial model_clear();

   always @(posedge clk) begin
      cyc = cyc + 1;
      if (!rst_n) begin
         model_clear();
      end else begin
         bit issued, s_out, c_out, busy_in, feed, nflag, narm;
         issued  = dq[$] & ~m_last;
         s_out   = sq[$];
         c_out   = cq[$];
         busy_in = m_arm & ~conv_eoc;
         feed    = m_flag & ~c_out;
         nflag   = s_out | (m_flag & ~c_out);
         narm    = issued | (m_arm & conv_eoc);
         m_last  = dq[$];
         dq.push_front(feed);      void'(dq.pop_back());
         cq.push_front(busy_in);   void'(cq.pop_back());
         sq.push_front(start_req); void'(sq.pop_back());
         m_flag = nflag;
         m_arm  = narm;
         m_exp  = dq[$] & ~m_last;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, expv, cyc);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   // Per-cycle comparison against the model, away from the active edge.
   always @(negedge clk) begin
      if (rst_n) begin
         chk(conv_start === m_exp, "R3/R4/R5/R7 model", int'(conv_start), int'(m_exp));
         if (conv_start) pulse_at.push_back(cyc);
      end else begin
         chk(conv_start === 1'b0, "R1 in reset", int'(conv_start), 0);
      end
   end

   always @(posedge clk) begin
      if (cyc > 20000) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
         finish_run();
      end
   end

   task automatic pulse_req();
      start_req = 1'b1;
      @(negedge clk);
      start_req = 1'b0;
   endtask

   int c0, cr;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (6) @(negedge clk);
      chk(pulse_at.size() == 0, "R1 idle after reset", pulse_at.size(), 0);

      // Single-clock request.
      pulse_at.delete();
      c0 = cyc;
      pulse_req();
      repeat (40) @(negedge clk);
      chk(pulse_at.size() == 1, "R2 short request captured", pulse_at.size(), 1);
      chk(pulse_at.size() > 0 && pulse_at[0] == c0 + 7, "R3 latency",
          pulse_at.size() > 0 ? pulse_at[0] - c0 : -1, 7);
      chk(pulse_at.size() < 2, "R5 no pulse after clear", pulse_at.size(), 1);

      // Second request while the flag is still set is merged.
      pulse_at.delete();
      c0 = cyc;
      pulse_req();
      @(negedge clk);
      pulse_req();
      repeat (40) @(negedge clk);
      chk(pulse_at.size() == 1, "R6 merged request", pulse_at.size(), 1);

      // Request on the first clock after the converter returns idle.
      pulse_at.delete();
      pulse_req();
      while (!conv_start) @(negedge clk);
      @(negedge clk);
      while (!conv_eoc) @(negedge clk);
      cr = cyc;
      pulse_req();
      repeat (40) @(negedge clk);
      chk(pulse_at.size() == 2, "R6 guard request kept", pulse_at.size(), 2);
      chk(pulse_at.size() == 2 && pulse_at[1] - cr >= 4, "R6 guard distance",
          pulse_at.size() == 2 ? pulse_at[1] - cr : -1, 7);

      // Held request: repeated pulses.
      pulse_at.delete();
      c0 = cyc;
      start_req = 1'b1;
      repeat (30) @(negedge clk);
      start_req = 1'b0;
      repeat (40) @(negedge clk);
      chk(pulse_at.size() >= 3, "R7 repeats while held", pulse_at.size(), 5);
      chk(pulse_at.size() > 0 && pulse_at[0] == c0 + 7, "R3 held first pulse",
          pulse_at.size() > 0 ? pulse_at[0] - c0 : -1, 7);
      for (int i = 1; i < pulse_at.size(); i++) begin
         chk(pulse_at[i] - pulse_at[i-1] == 7, "R7 restart period",
             pulse_at[i] - pulse_at[i-1], 7);
         chk(pulse_at[i] - pulse_at[i-1] != 1, "R4 single width",
             pulse_at[i] - pulse_at[i-1], 7);
      end

      // Reset with a request in flight discards it.
      pulse_at.delete();
      pulse_req();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (20) @(negedge clk);
      chk(pulse_at.size() == 0, "R1 reset drops request", pulse_at.size(), 0);

      finish_run();
   end

endmodule